// File: doc/BRIEF.md
# Dual-Source Change-of-Flow Trace Recorder

This block records program-flow history from two processors that run side by side: a main CPU with a 24-bit program counter and a coprocessor with a 16-bit program counter. Each processor presents a change-of-flow (COF) strobe, its current program counter, seven flag bits (read/write and similar), and, for detail tracing, an access strobe with address, data and a word/byte qualifier. The recorder turns these events into 64-bit lines and stores them in an on-chip trace RAM of `LINES` lines. The RAM wraps when it is full, and a sticky flag records that it has wrapped.

Two inputs set how events are recorded. The source select picks both processors, the CPU alone, or the coprocessor alone. The format select picks normal, loop1 or detail. In dual-source tracing, every COF writes one line. That line holds the processor that branched, with its valid flag set, and a snapshot of the other processor's program counter, whose valid flag stays clear unless it also branched in that cycle. In single-source normal or loop1 tracing, two 32-bit entries share one line. In single-source detail tracing, each data access writes one line holding its address and its data bytes.

An entry counter counts the entries written. Its upper bits are the line write pointer. Its bit 0 counts half-lines only in the two-entries-per-line modes. A synchronous read port returns any line one cycle after it is requested. A clear input restarts the recording.

Top module: `cof_trace_recorder`

## Requirements
- R1: After reset, `entry_cnt` is 0, `full` is 0 and `rd_data` is 0.
- R2: Encodings: `src_sel` 00 or 11 selects both sources, 01 the CPU only, 10 the coprocessor only. `fmt` 00 or 11 selects normal, 01 loop1, 10 detail; detail with both sources behaves as normal. A dual-source line is {cop valid, cop_flags[6:0]} in bits 63:56, cop_pc in 55:40, {cpu valid, cpu_flags[6:0]} in 39:32, cpu_pc in 31:8, and zero in 7:0. A lone CPU COF sets the CPU valid bit and stores the coprocessor PC as a snapshot with its valid bit clear.
- R3: A lone coprocessor COF in dual-source mode sets the coprocessor valid bit and stores the CPU PC as a snapshot with the CPU valid bit clear.
- R4: COFs from both sources in the same cycle write one line with both valid bits set. COFs on consecutive cycles each write their own line.
- R5: In single-source normal mode, an entry is {1'b1, flags[6:0], pc} (the coprocessor PC is zero-extended to 24 bits). The even-numbered entry goes to bits 31:0 of the line, with 63:32 zero until the odd-numbered entry fills bits 63:32.
- R6: In single-source normal and loop1 modes, `entry_cnt` advances by 1 per entry. In every other mode it advances by 2 per entry and bit 0 is 0. Entries are written to line `entry_cnt[CNT_W-1:1]`.
- R7: Loop1 mode stores entries exactly as normal mode does.
- R8: A detail line is {1'b1, flags[6:0]} in bits 63:56, the access address (coprocessor address zero-extended) in 55:32, data byte 3 in 31:24, data byte 2 in 23:16, and zero in 15:0. A word access puts data[15:8] (the lower-address byte) in byte 3 and data[7:0] in byte 2. A byte access puts data[7:0] in byte 2 and clears byte 3.
- R9: When the write pointer wraps from the last line back to line 0, `full` is set. It stays set until clear or reset, and later entries overwrite from line 0.
- R10: When `rd_en` is high, `rd_data` shows line `rd_addr` after the next clock edge. When `rd_en` is low, `rd_data` holds its value.
- R11: `clr` zeroes `entry_cnt` and `full` in the next cycle. It takes priority over an entry in the same cycle, which is then not written.
- R12: Strobes that the current mode does not trace (the unselected source, COF strobes in detail mode, access strobes outside detail mode) write nothing and leave `entry_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Restart recording (counter and full flag) |
| src_sel | input | 2 | Traced sources |
| fmt | input | 2 | Entry format |
| cpu_cof | input | 1 | CPU change-of-flow strobe |
| cpu_flags | input | 7 | CPU info flags |
| cpu_pc | input | 24 | CPU program counter |
| cpu_acc | input | 1 | CPU data access strobe |
| cpu_acc_word | input | 1 | CPU access is a word |
| cpu_addr | input | 24 | CPU access address |
| cpu_data | input | 16 | CPU access data |
| cop_cof | input | 1 | Coprocessor change-of-flow strobe |
| cop_flags | input | 7 | Coprocessor info flags |
| cop_pc | input | 16 | Coprocessor program counter |
| cop_acc | input | 1 | Coprocessor data access strobe |
| cop_acc_word | input | 1 | Coprocessor access is a word |
| cop_addr | input | 16 | Coprocessor access address |
| cop_data | input | 16 | Coprocessor access data |
| rd_en | input | 1 | Read request |
| rd_addr | input | PTR_W (6) | Line to read |
| rd_data | output | 64 | Registered read data |
| entry_cnt | output | CNT_W (7) | Entry counter; upper bits are the write pointer |
| full | output | 1 | Sticky wrap flag |

## Verification
A corrupted counter appears on `entry_cnt` in the cycle after the entry that caused it. A wrong write pointer or a stale half-line register only appears at the read port: the line read back one cycle after the request holds a misplaced or mixed entry. A wrong valid-bit or byte-lane choice appears in the same read-back line. A `full` flag that never sets, or that clears on its own, shows at the wrap boundary and on the first entry after it.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

    localparam int LINE_W = 64;
    localparam int HALF_W = 32;
    localparam int PC_W   = 24;
    localparam int FLG_W  = 7;
    localparam int DAT_W  = 16;

    typedef enum logic [1:0] {
        SRC_BOTH     = 2'b00,
        SRC_CPU      = 2'b01,
        SRC_COP      = 2'b10,
        SRC_BOTH_ALT = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        FMT_NORMAL = 2'b00,
        FMT_LOOP1  = 2'b01,
        FMT_DETAIL = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;

    typedef struct packed {
        logic             cof;
        logic [FLG_W-1:0] flags;
        logic [PC_W-1:0]  pc;
        logic             acc;
        logic             acc_word;
        logic [PC_W-1:0]  addr;
        logic [DAT_W-1:0] data;
    } src_in_t;

endpackage

// File: rtl/cof_entry_fmt.sv
module cof_entry_fmt
    import cof_trace_pkg::*;
(
    input  src_sel_e          src_sel,
    input  fmt_e              fmt,
    input  src_in_t           cpu_s,
    input  src_in_t           cop_s,
    output logic              entry_vld,
    output logic              pair_mode,
    output logic [HALF_W-1:0] half_o,
    output logic [LINE_W-1:0] line_o
);

    logic    dual_d;
    logic    detail_d;
    src_in_t sel_d;
    logic [7:0] hi_byte_d;

    always_comb begin
        dual_d    = (src_sel == SRC_BOTH) || (src_sel == SRC_BOTH_ALT);
        detail_d  = (fmt == FMT_DETAIL) && !dual_d;
        sel_d     = (src_sel == SRC_CPU) ? cpu_s : cop_s;
        hi_byte_d = sel_d.acc_word ? sel_d.data[15:8] : 8'h00;
        pair_mode = !dual_d && !detail_d;
        half_o    = {1'b1, sel_d.flags, sel_d.pc};
        entry_vld = 1'b0;
        line_o    = '0;
        if (dual_d) begin
            entry_vld = cpu_s.cof || cop_s.cof;
            line_o    = {cop_s.cof, cop_s.flags, cop_s.pc[15:0],
                         cpu_s.cof, cpu_s.flags, cpu_s.pc, 8'h00};
        end else if (detail_d) begin
            entry_vld = sel_d.acc;
            line_o    = {1'b1, sel_d.flags, sel_d.addr,
                         hi_byte_d, sel_d.data[7:0], 16'h0000};
        end else begin
            entry_vld = sel_d.cof;
        end
    end

endmodule

// File: rtl/cof_trace_ctrl.sv
module cof_trace_ctrl
    import cof_trace_pkg::*;
#(
    parameter int LINES = 64,
    localparam int PTR_W = $clog2(LINES),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              entry_vld,
    input  logic              pair_mode,
    input  logic [HALF_W-1:0] half_in,
    input  logic [LINE_W-1:0] line_in,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [LINE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt,
    output logic              full
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              full;
        logic [HALF_W-1:0] stage;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [CNT_W-1:0] base_d;
    logic [CNT_W:0]   sum_d;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = st_q.cnt[CNT_W-1:1];
        wr_data = line_in;
        base_d  = pair_mode ? st_q.cnt : {st_q.cnt[CNT_W-1:1], 1'b0};
        sum_d   = {1'b0, base_d} + (pair_mode ? (CNT_W+1)'(1) : (CNT_W+1)'(2));
        if (clr) begin
            st_d = '0;
        end else if (entry_vld) begin
            wr_en = 1'b1;
            if (pair_mode) begin
                if (!st_q.cnt[0]) begin
                    wr_data    = {{HALF_W{1'b0}}, half_in};
                    st_d.stage = half_in;
                end else begin
                    wr_data = {half_in, st_q.stage};
                end
            end
            st_d.cnt  = sum_d[CNT_W-1:0];
            st_d.full = st_q.full || sum_d[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign full = st_q.full;

    // R6
    cnt_lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_vld && !pair_mode && !clr) |=> !st_q.cnt[0]);

    // R6
    pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_vld && pair_mode && !clr) |=> st_q.cnt == $past(st_q.cnt) + CNT_W'(1));

    // R9
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !clr) |=> st_q.full);

    // R11
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && !st_q.full));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry_vld && !clr) |=> $stable(st_q.cnt));

endmodule

// File: rtl/cof_trace_ram.sv
module cof_trace_ram
    import cof_trace_pkg::*;
#(
    parameter int LINES = 64,
    localparam int PTR_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [LINE_W-1:0] rd_data
);

    logic [LINE_W-1:0] mem_q [LINES];
    logic [LINE_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_en ? mem_q[rd_addr] : rd_q;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/cof_trace_recorder.sv
module cof_trace_recorder
    import cof_trace_pkg::*;
#(
    parameter int LINES = 64,
    localparam int PTR_W = $clog2(LINES),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [1:0]        src_sel,
    input  logic [1:0]        fmt,
    input  logic              cpu_cof,
    input  logic [6:0]        cpu_flags,
    input  logic [23:0]       cpu_pc,
    input  logic              cpu_acc,
    input  logic              cpu_acc_word,
    input  logic [23:0]       cpu_addr,
    input  logic [15:0]       cpu_data,
    input  logic              cop_cof,
    input  logic [6:0]        cop_flags,
    input  logic [15:0]       cop_pc,
    input  logic              cop_acc,
    input  logic              cop_acc_word,
    input  logic [15:0]       cop_addr,
    input  logic [15:0]       cop_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [63:0]       rd_data,
    output logic [CNT_W-1:0]  entry_cnt,
    output logic              full
);

    src_in_t cpu_s, cop_s;
    logic              entry_vld, pair_mode, wr_en;
    logic [HALF_W-1:0] half_w;
    logic [LINE_W-1:0] line_w, wr_data;
    logic [PTR_W-1:0]  wr_addr;

    always_comb begin
        cpu_s = '{cof: cpu_cof, flags: cpu_flags, pc: cpu_pc, acc: cpu_acc,
                  acc_word: cpu_acc_word, addr: cpu_addr, data: cpu_data};
        cop_s = '{cof: cop_cof, flags: cop_flags, pc: {8'h00, cop_pc}, acc: cop_acc,
                  acc_word: cop_acc_word, addr: {8'h00, cop_addr}, data: cop_data};
    end

    cof_entry_fmt u_fmt (
        .src_sel   (src_sel_e'(src_sel)),
        .fmt       (fmt_e'(fmt)),
        .cpu_s     (cpu_s),
        .cop_s     (cop_s),
        .entry_vld (entry_vld),
        .pair_mode (pair_mode),
        .half_o    (half_w),
        .line_o    (line_w)
    );

    cof_trace_ctrl #(.LINES(LINES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .entry_vld (entry_vld),
        .pair_mode (pair_mode),
        .half_in   (half_w),
        .line_in   (line_w),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt       (entry_cnt),
        .full      (full)
    );

    cof_trace_ram #(.LINES(LINES)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/tb_cof_trace_recorder.sv
module tb_cof_trace_recorder;

    logic        clk = 1'b0;
    logic        rst_n, clr;
    logic [1:0]  src_sel, fmt;
    logic        cpu_cof, cpu_acc, cpu_acc_word;
    logic [6:0]  cpu_flags, cop_flags;
    logic [23:0] cpu_pc, cpu_addr;
    logic [15:0] cpu_data, cop_pc, cop_addr, cop_data;
    logic        cop_cof, cop_acc, cop_acc_word;
    logic        rd_en;
    logic [5:0]  rd_addr;
    logic [63:0] rd_data;
    logic [6:0]  entry_cnt;
    logic        full;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    cof_trace_recorder dut (.*);

    typedef struct packed {
        logic        c_cof;
        logic        x_cof;
        logic [23:0] cpc;
        logic [15:0] xpc;
        logic [6:0]  cflg;
        logic [6:0]  xflg;
        logic [63:0] exp;
    } vec_t;

    // dual-source vectors: R2 (CPU alone), R3 (coprocessor alone), R4 (both)
    localparam vec_t VECS [4] = '{
        '{1'b1, 1'b0, 24'h123456, 16'hABCD, 7'h05, 7'h0A, 64'h0AAB_CD85_1234_5600},
        '{1'b0, 1'b1, 24'h000102, 16'h3344, 7'h7F, 7'h11, 64'h9133_447F_0001_0200},
        '{1'b1, 1'b1, 24'hFEDCBA, 16'h0F0F, 7'h00, 7'h00, 64'h800F_0F80_FEDC_BA00},
        '{1'b1, 1'b0, 24'hA5A5A5, 16'h5A5A, 7'h7E, 7'h01, 64'h015A_5AFE_A5A5_A500}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_line(input int a, output logic [63:0] d);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a[5:0];
        @(negedge clk);
        rd_en = 1'b0;
        d     = rd_data;
    endtask

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d, held;
        rst_n = 1'b0; clr = 1'b0; src_sel = 2'b00; fmt = 2'b00;
        cpu_cof = 0; cpu_acc = 0; cpu_acc_word = 0; cpu_flags = 0; cpu_pc = 0;
        cpu_addr = 0; cpu_data = 0; cop_cof = 0; cop_acc = 0; cop_acc_word = 0;
        cop_flags = 0; cop_pc = 0; cop_addr = 0; cop_data = 0; rd_en = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset count", 64'(entry_cnt), 64'd0);
        chk("R1 reset full", 64'(full), 64'd0);
        chk("R1 reset rd_data", rd_data, 64'd0);

        // dual-source table, one vector per consecutive cycle
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cpu_cof = VECS[i].c_cof; cop_cof = VECS[i].x_cof;
            cpu_pc = VECS[i].cpc; cop_pc = VECS[i].xpc;
            cpu_flags = VECS[i].cflg; cop_flags = VECS[i].xflg;
        end
        @(negedge clk);
        cpu_cof = 0; cop_cof = 0;
        chk("R4/R6 count after four dual entries", 64'(entry_cnt), 64'd8);
        for (int i = 0; i < 4; i++) begin
            rd_line(i, d);
            chk("R2/R3/R4 dual line", d, VECS[i].exp);
        end

        // R9 wrap and sticky full
        do_clr();
        @(negedge clk);
        cpu_cof = 1; cop_pc = 16'h0; cop_flags = 0; cpu_flags = 0;
        repeat (63) @(negedge clk);
        cpu_cof = 0;
        chk("R9 count before wrap", 64'(entry_cnt), 64'd126);
        chk("R9 full before wrap", 64'(full), 64'd0);
        cpu_cof = 1;
        @(negedge clk);
        cpu_cof = 0;
        chk("R9 count wraps", 64'(entry_cnt), 64'd0);
        chk("R9 full on wrap", 64'(full), 64'd1);
        cpu_cof = 1; cpu_pc = 24'hCAFE00;
        @(negedge clk);
        cpu_cof = 0;
        chk("R9 full sticky", 64'(full), 64'd1);
        chk("R9 count after wrap", 64'(entry_cnt), 64'd2);
        rd_line(0, d);
        chk("R9 line 0 overwritten", d, 64'h0000_0080_CAFE_0000);

        // R5 single-source CPU, normal
        do_clr();
        src_sel = 2'b01; fmt = 2'b00;
        @(negedge clk);
        cpu_cof = 1; cpu_pc = 24'h111111; cpu_flags = 7'h03;
        @(negedge clk);
        cpu_cof = 0;
        chk("R6 pair count 1", 64'(entry_cnt), 64'd1);
        rd_line(0, d);
        chk("R5 even entry low half", d, 64'h0000_0000_8311_1111);
        @(negedge clk);
        cop_cof = 1;
        @(negedge clk);
        cop_cof = 0;
        chk("R12 unselected source ignored", 64'(entry_cnt), 64'd1);
        cpu_cof = 1; cpu_pc = 24'h222222; cpu_flags = 7'h04;
        @(negedge clk);
        cpu_cof = 0;
        chk("R6 pair count 2", 64'(entry_cnt), 64'd2);
        rd_line(0, d);
        chk("R5 odd entry upper half", d, 64'h8422_2222_8311_1111);
        held = rd_data;
        cpu_cof = 1;
        repeat (2) @(negedge clk);
        cpu_cof = 0;
        @(negedge clk);
        chk("R10 rd_data holds without rd_en", rd_data, held);

        // R7 loop1, coprocessor only
        do_clr();
        src_sel = 2'b10; fmt = 2'b01;
        @(negedge clk);
        cop_cof = 1; cop_pc = 16'hBEEF; cop_flags = 7'h40;
        @(negedge clk);
        cop_pc = 16'h1234; cop_flags = 7'h00;
        @(negedge clk);
        cop_cof = 0;
        chk("R7 loop1 count", 64'(entry_cnt), 64'd2);
        rd_line(0, d);
        chk("R7 loop1 line", d, 64'h8000_1234_C000_BEEF);

        // R8 detail, CPU then coprocessor
        do_clr();
        src_sel = 2'b01; fmt = 2'b10;
        @(negedge clk);
        cpu_acc = 1; cpu_acc_word = 0; cpu_addr = 24'h004000; cpu_data = 16'h775A; cpu_flags = 7'h01;
        @(negedge clk);
        cpu_acc_word = 1; cpu_addr = 24'h004002; cpu_data = 16'hC3D4; cpu_flags = 7'h02;
        @(negedge clk);
        cpu_acc = 0; cpu_acc_word = 0;
        chk("R6 detail count step 2", 64'(entry_cnt), 64'd4);
        rd_line(0, d);
        chk("R8 byte access", d, 64'h8100_4000_005A_0000);
        rd_line(1, d);
        chk("R8 word access", d, 64'h8200_4002_C3D4_0000);
        @(negedge clk);
        cpu_cof = 1;
        @(negedge clk);
        cpu_cof = 0;
        chk("R12 COF ignored in detail", 64'(entry_cnt), 64'd4);
        src_sel = 2'b10;
        cop_acc = 1; cop_acc_word = 1; cop_addr = 16'h2468; cop_data = 16'h0102; cop_flags = 7'h00;
        @(negedge clk);
        cop_acc = 0; cop_acc_word = 0;
        chk("R6 detail count 6", 64'(entry_cnt), 64'd6);
        rd_line(2, d);
        chk("R8 coprocessor word", d, 64'h8000_2468_0102_0000);

        // R11 clear beats a same-cycle entry
        @(negedge clk);
        clr = 1; src_sel = 2'b01; fmt = 2'b00; cpu_cof = 1; cpu_pc = 24'h999999;
        @(negedge clk);
        clr = 0; cpu_cof = 0;
        chk("R11 clear count", 64'(entry_cnt), 64'd0);
        chk("R11 clear full", 64'(full), 64'd0);
        rd_line(0, d);
        chk("R11 entry dropped on clear", d, 64'h8100_4000_005A_0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule